// File: doc/BRIEF.md
# Dual-Compare 16-bit Interval Timer

This block is a 16-bit up-counter with two 16-bit compare values, programmed through a byte-wide register port. An external prescaler supplies a one-cycle `tick_i` pulse. A mode register sets how ticks become counts: one count per tick, one count per sixteen ticks, or no counting at all. Each time the counter steps onto the value held in compare A, a one-cycle pulse appears on `irq_a_o`. Each time it steps onto compare B, a pulse appears on `irq_b_o`. If the period bit of the mode register is set, that match also returns the counter to zero, so compare B then sets the period of the timer.

Counting is gated by a run-control register that other timers share. This timer counts only while its own run bit and the shared prescaler-run bit are both set. The moment both become set is a start: the counter and the divide-by-16 stage are both cleared. Clearing either bit freezes the counter at its current value. Software reads the compare bytes, the mode, the run register and the live count through a combinational read port.

Top module: `timer16_dual_cmp`

## Requirements
- R1: After reset the count, both compare values, the mode register and the run register read as zero, and both interrupt outputs are low.
- R2: Compare A low/high bytes are at addresses 0/1 and compare B low/high bytes at 2/3. A write to one of these addresses replaces only that byte and leaves the other byte of the same compare value unchanged.
- R3: The mode register (address 4) reads back the full 8-bit value last written. Bits [1:0] set the rate and bit 2 is the period (clear-on-B) enable.
- R4: With rate 1 the counter advances by one on every accepted tick. With rate 2 it advances once per 16 accepted ticks. With rate 0 or 3 it does not advance.
- R5: Ticks are accepted only while run-register (address 5) bit 4 (own run) and bit 5 (shared prescaler run) are both set. Otherwise the count holds its value.
- R6: A write to the run register that sets both run bits while they were not both set is a start. It clears the counter to zero and restarts the divide-by-16 stage, and a tick in that same cycle is ignored.
- R7: A counter step onto the value of compare A produces a one-cycle high pulse on `irq_a_o`, in the cycle after the step's clock edge.
- R8: A counter step onto the value of compare B produces a one-cycle pulse on `irq_b_o`. If mode bit 2 is set, the counter becomes zero instead of holding the matched value.
- R9: Without a clearing match, the counter wraps from 0xFFFF to 0x0000 on the next step, and a step onto 0x0000 can match a compare value of zero.
- R10: When both compare values equal the stepped count, both interrupt outputs pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address (6/7 = count low/high) |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| count_o | output | 16 | Current counter value |
| irq_a_o | output | 1 | Compare A match pulse |
| irq_b_o | output | 1 | Compare B match pulse |

## Verification
A tick or register write that is present at a clock edge takes effect at that edge. The new count and any interrupt pulse are therefore visible from just after that edge, with one register stage in between. Read data follows `rd_addr_i` with no delay. The bench drives inputs at the falling edge and updates its reference model at the rising edge using the values held before that edge, because compare and mode writes take effect only after the step they coincide with. It samples two time units after the rising edge, reading registers back within that same half period. Divide-by-16 and wrap results are checked at the exact 16th and 65536th tick.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CMPA_LO = 3'd0,
    A_CMPA_HI = 3'd1,
    A_CMPB_LO = 3'd2,
    A_CMPB_HI = 3'd3,
    A_MODE    = 3'd4,
    A_RUN     = 3'd5,
    A_CNT_LO  = 3'd6,
    A_CNT_HI  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    RATE_HALT0 = 2'd0,
    RATE_DIV1  = 2'd1,
    RATE_DIVN  = 2'd2,
    RATE_HALT3 = 2'd3
  } rate_e;

  localparam int MODE_CLR_BIT = 2;

  // Replace one byte of a compare value, keep the other.
  function automatic logic [CW-1:0] put_byte(input logic [CW-1:0] old_v,
                                             input logic hi_sel,
                                             input logic [DW-1:0] b);
    logic [CW-1:0] r;
    r = old_v;
    if (hi_sel) r[CW-1:DW] = b;
    else        r[DW-1:0]  = b;
    return r;
  endfunction

  // Counter successor with natural wrap.
  function automatic logic [CW-1:0] incr_wrap(input logic [CW-1:0] v);
    return v + {{(CW-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/timer16_regs.sv
module timer16_regs
  import timer16_pkg::*;
#(
  parameter int OWN_RUN_BIT    = 4,
  parameter int SHARED_RUN_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] cmp_a,
  output logic [CW-1:0] cmp_b,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] run_q,
  output logic          run_en,
  output logic          start_evt
);
  localparam int NCMP = 2;

  logic [CW-1:0] cmp_q [NCMP];

  genvar gi;
  generate
    for (gi = 0; gi < NCMP; gi++) begin : g_cmp
      localparam logic [AW-1:0] LO_ADDR = AW'(2 * gi);
      localparam logic [AW-1:0] HI_ADDR = AW'(2 * gi + 1);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cmp_q[gi] <= '0;
        end else if (wr_en && (wr_addr == LO_ADDR || wr_addr == HI_ADDR)) begin
          cmp_q[gi] <= put_byte(cmp_q[gi], wr_addr == HI_ADDR, wr_data);
        end
      end
    end
  endgenerate

  assign cmp_a = cmp_q[0];
  assign cmp_b = cmp_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE) mode_q <= wr_data;
      if (wr_addr == A_RUN)  run_q  <= wr_data;
    end
  end

  logic wr_sets_both;
  assign run_en       = run_q[OWN_RUN_BIT] & run_q[SHARED_RUN_BIT];
  assign wr_sets_both = wr_data[OWN_RUN_BIT] & wr_data[SHARED_RUN_BIT];
  assign start_evt    = wr_en && (wr_addr == A_RUN) && wr_sets_both && !run_en;
endmodule

// File: rtl/timer16_presc.sv
module timer16_presc
  import timer16_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run_en,
  input  logic       start_evt,
  input  logic [1:0] rate,
  output logic       step_evt
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic accept;
  logic [DIV_W-1:0] div_q;

  assign accept = tick && run_en && !start_evt;

  always_ff @(posedge clk) begin
    if (!rst_n || start_evt) begin
      div_q <= '0;
    end else if (accept && rate == RATE_DIVN) begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  always_comb begin
    unique case (rate_e'(rate))
      RATE_DIV1: step_evt = accept;
      RATE_DIVN: step_evt = accept && (div_q == DIV_LAST);
      default:   step_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/timer16_core.sv
module timer16_core
  import timer16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_evt,
  input  logic          start_evt,
  input  logic          clear_on_b,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  output logic [CW-1:0] count,
  output logic          match_a,
  output logic          match_b,
  output logic          irq_a,
  output logic          irq_b
);
  logic [CW-1:0] next_cnt;

  assign next_cnt = incr_wrap(count);
  assign match_a  = step_evt && (next_cnt == cmp_a);
  assign match_b  = step_evt && (next_cnt == cmp_b);

  always_ff @(posedge clk) begin
    if (!rst_n || start_evt) begin
      count <= '0;
    end else if (step_evt) begin
      count <= (match_b && clear_on_b) ? '0 : next_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      irq_a <= match_a;
      irq_b <= match_b;
    end
  end
endmodule

// File: rtl/timer16_dual_cmp.sv
module timer16_dual_cmp
  import timer16_pkg::*;
#(
  parameter int PRESC_DIV      = 16,
  parameter int OWN_RUN_BIT    = 4,
  parameter int SHARED_RUN_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          irq_a_o,
  output logic          irq_b_o
);
  logic [CW-1:0] cmp_a, cmp_b, count;
  logic [DW-1:0] mode_q, run_q;
  logic          run_en, start_evt, step_evt, match_a, match_b;

  timer16_regs #(
    .OWN_RUN_BIT(OWN_RUN_BIT),
    .SHARED_RUN_BIT(SHARED_RUN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_q(mode_q), .run_q(run_q),
    .run_en(run_en), .start_evt(start_evt)
  );

  timer16_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run_en(run_en),
    .start_evt(start_evt), .rate(mode_q[1:0]), .step_evt(step_evt)
  );

  timer16_core u_core (
    .clk(clk), .rst_n(rst_n), .step_evt(step_evt), .start_evt(start_evt),
    .clear_on_b(mode_q[MODE_CLR_BIT]), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .count(count), .match_a(match_a), .match_b(match_b),
    .irq_a(irq_a_o), .irq_b(irq_b_o)
  );

  assign count_o = count;

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      A_CMPA_LO: rd_data_o = cmp_a[DW-1:0];
      A_CMPA_HI: rd_data_o = cmp_a[CW-1:DW];
      A_CMPB_LO: rd_data_o = cmp_b[DW-1:0];
      A_CMPB_HI: rd_data_o = cmp_b[CW-1:DW];
      A_MODE:    rd_data_o = mode_q;
      A_RUN:     rd_data_o = run_q;
      A_CNT_LO:  rd_data_o = count[DW-1:0];
      default:   rd_data_o = count[CW-1:DW];
    endcase
  end
endmodule

// File: rtl/timer16_checker.sv
module timer16_checker
  import timer16_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] mode_q,
  input logic          run_en,
  input logic          start_evt,
  input logic          step_evt,
  input logic [CW-1:0] count,
  input logic          irq_a,
  input logic          irq_b
);
  assert_mode_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MODE) |=> mode_q == $past(wr_data));

  assert_step_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> (run_en && (mode_q[1:0] == RATE_DIV1 || mode_q[1:0] == RATE_DIVN)));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !start_evt) |=> $stable(count));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> count == '0);

  assert_irq_a_from_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_a) |-> $past(step_evt));

  assert_period_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_b && $past(mode_q[MODE_CLR_BIT])) |-> count == '0);

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && count == '1) |=> count == '0);
endmodule

bind timer16_dual_cmp timer16_checker i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
  .wr_data(wr_data_i), .mode_q(mode_q), .run_en(run_en),
  .start_evt(start_evt), .step_evt(step_evt), .count(count),
  .irq_a(irq_a_o), .irq_b(irq_b_o)
);

// File: tb/test_timer16_dual_cmp.sv
module test_timer16_dual_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [15:0] count_o;
  logic irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_cmpa, m_cmpb, m_cnt;
  logic [7:0]  m_mode, m_run;
  int          m_div;
  logic        m_ia, m_ib;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer16_dual_cmp i_timer16_dual_cmp (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .count_o(count_o), .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic running(input logic [7:0] r);
    return r[4] && r[5];
  endfunction

  // Expected count after one step, given clear rules
  function automatic logic [15:0] after_step(input logic [15:0] c, input logic [15:0] cb,
                                              input logic clr);
    int n;
    n = (int'(c) + 1) % 65536;
    if (clr && n == int'(cb)) return 16'h0000;
    return 16'(n);
  endfunction

  task automatic model_edge(input logic we, input logic [2:0] a, input logic [7:0] d,
                            input logic tk);
    logic adv;
    logic [15:0] nxt;
    adv = 1'b0;
    m_ia = 1'b0;
    m_ib = 1'b0;
    if (we && a == 3'd5 && d[4] && d[5] && !running(m_run)) begin
      m_cnt = '0;
      m_div = 0;
    end else if (running(m_run) && tk) begin
      if (m_mode[1:0] == 2'd1) adv = 1'b1;
      else if (m_mode[1:0] == 2'd2) begin
        m_div = m_div + 1;
        if (m_div == 16) begin
          adv = 1'b1;
          m_div = 0;
        end
      end
      if (adv) begin
        nxt = 16'(m_cnt + 16'd1);
        m_ia = (nxt == m_cmpa);
        m_ib = (nxt == m_cmpb);
        m_cnt = after_step(m_cnt, m_cmpb, m_mode[2]);
      end
    end
    if (we) begin
      case (a)
        3'd0: m_cmpa[7:0]  = d;
        3'd1: m_cmpa[15:8] = d;
        3'd2: m_cmpb[7:0]  = d;
        3'd3: m_cmpb[15:8] = d;
        3'd4: m_mode = d;
        3'd5: m_run  = d;
        default: ;
      endcase
    end
  endtask

  task automatic do_cyc(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic tk);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    @(posedge clk);
    model_edge(we, a, d, tk);
    #2;
    chk("R4 count", {16'h0, count_o}, {16'h0, m_cnt});
    chk("R7 irq_a", {31'h0, irq_a}, {31'h0, m_ia});
    chk("R8 irq_b", {31'h0, irq_b}, {31'h0, m_ib});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    do_cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20531));
    m_cmpa = '0; m_cmpb = '0; m_cnt = '0; m_mode = '0; m_run = '0;
    m_div = 0; m_ia = 0; m_ib = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 count", {16'h0, count_o}, 32'h0);
    chk("R1 irq_a", {31'h0, irq_a}, 32'h0);
    chk("R1 irq_b", {31'h0, irq_b}, 32'h0);
    for (int a = 0; a < 6; a++) rd_chk("R1 reg", 3'(a), 8'h00);

    // R2 byte-wise compare writes
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd_chk("R2 cmpA lo", 3'd0, 8'h34);
    rd_chk("R2 cmpA hi", 3'd1, 8'h12);
    wr(3'd0, 8'h56);
    rd_chk("R2 cmpA hi kept", 3'd1, 8'h12);
    rd_chk("R2 cmpA lo new", 3'd0, 8'h56);
    wr(3'd3, 8'h9A);
    rd_chk("R2 cmpB lo kept", 3'd2, 8'h00);
    rd_chk("R2 cmpB hi new", 3'd3, 8'h9A);

    // R3 mode readback
    wr(3'd4, 8'hA9);
    rd_chk("R3 mode", 3'd4, 8'hA9);
    wr(3'd4, 8'h01);
    rd_chk("R3 mode", 3'd4, 8'h01);

    // R5 gating by both run bits
    wr(3'd5, 8'h10);
    ticks(3);
    chk("R5 own only", {16'h0, count_o}, 32'h0);
    wr(3'd5, 8'h30);
    ticks(4);
    chk("R5 running", {16'h0, count_o}, 32'd4);
    wr(3'd5, 8'h20);
    ticks(3);
    chk("R5 hold", {16'h0, count_o}, 32'd4);
    rd_chk("R5 count lo read", 3'd6, 8'd4);
    // R6 restart clears
    wr(3'd5, 8'h30);
    chk("R6 start clears", {16'h0, count_o}, 32'h0);
    do_cyc(1'b1, 3'd5, 8'h30, 1'b1);
    chk("R6 rewrite while running not a start", {16'h0, count_o}, 32'd1);

    // R4 divide by 16 and halt rates
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h02);
    do_cyc(1'b1, 3'd5, 8'h30, 1'b1);
    chk("R6 tick ignored at start", {16'h0, count_o}, 32'h0);
    ticks(15);
    chk("R4 div16 early", {16'h0, count_o}, 32'h0);
    ticks(1);
    chk("R4 div16 step", {16'h0, count_o}, 32'd1);
    ticks(16);
    chk("R4 div16 second", {16'h0, count_o}, 32'd2);
    wr(3'd4, 8'h03);
    ticks(5);
    chk("R4 rate3 halt", {16'h0, count_o}, 32'd2);
    wr(3'd4, 8'h00);
    ticks(5);
    chk("R4 rate0 halt", {16'h0, count_o}, 32'd2);

    // R8 period clear on compare B
    wr(3'd5, 8'h00);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    wr(3'd2, 8'h05); wr(3'd3, 8'h00);
    wr(3'd4, 8'h05);
    wr(3'd5, 8'h30);
    ticks(5);
    chk("R8 irq_b", {31'h0, irq_b}, 32'd1);
    chk("R8 cleared", {16'h0, count_o}, 32'h0);
    ticks(1);
    chk("R8 pulse ends", {31'h0, irq_b}, 32'h0);
    chk("R8 counts on", {16'h0, count_o}, 32'd1);

    // R10 simultaneous pulses
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h03); wr(3'd1, 8'h00);
    wr(3'd2, 8'h03);
    wr(3'd4, 8'h01);
    wr(3'd5, 8'h30);
    ticks(3);
    chk("R10 irq_a", {31'h0, irq_a}, 32'd1);
    chk("R10 irq_b", {31'h0, irq_b}, 32'd1);
    chk("R10 no clear", {16'h0, count_o}, 32'd3);

    // R9 wrap
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h80);
    wr(3'd5, 8'h30);
    ticks(65535);
    chk("R9 top", {16'h0, count_o}, 32'hFFFF);
    ticks(1);
    chk("R9 wrapped", {16'h0, count_o}, 32'h0);
    chk("R9 match at zero", {31'h0, irq_a}, 32'd1);

    // constrained random mix, checked each cycle against the model
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) begin
        logic [7:0] mv [6];
        mv[0] = 8'h01; mv[1] = 8'h02; mv[2] = 8'h05;
        mv[3] = 8'h06; mv[4] = 8'h00; mv[5] = 8'h03;
        do_cyc(1'b1, 3'd4, mv[$urandom_range(0, 5)], 1'($urandom_range(0, 1)));
      end else if (r < 5) begin
        logic [7:0] rv [4];
        rv[0] = 8'h30; rv[1] = 8'h10; rv[2] = 8'h20; rv[3] = 8'h00;
        do_cyc(1'b1, 3'd5, rv[$urandom_range(0, 3)], 1'($urandom_range(0, 1)));
      end else if (r < 9) begin
        logic [2:0] a;
        logic [7:0] d;
        a = 3'($urandom_range(0, 3));
        d = a[0] ? 8'h00 : 8'($urandom_range(0, 40));
        do_cyc(1'b1, a, d, 1'($urandom_range(0, 1)));
      end else begin
        do_cyc(1'b0, 3'd0, 8'h00, 1'($urandom_range(0, 1)));
      end
    end
    rd_chk("R3 mode final", 3'd4, m_mode);
    rd_chk("R2 cmpB lo final", 3'd2, m_cmpb[7:0]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule